// File: doc/BRIEF.md
# Low-speed USB receive sync and bit-phase tracker

This block sits between the raw D-/D+ pins of a low-speed USB port and a serial decoder. It runs from a system clock of exactly eleven clocks per line bit and looks for the start of a packet on the D- line. Idle (J) shows D- high and K shows D- low. The block needs a K edge from idle, then J, then a further J-to-K edge found to within one clock. It confirms the end of the sync field when the line is still K one bit and a half later. A search that finds no K edge in time is counted as a missed start.

Once sync is confirmed, the block drives a one-clock strobe near the centre of every following bit, together with the synchronized line pair sampled at that moment. Each line transition is compared with the expected bit boundary. When the edge arrives early or late, the next strobe moves by one clock. This keeps the strobe centred against a clock error of about one percent. The strobes run until the decoder reports end of packet.

Top module: `lsrx_sync_lock`

## Requirements
- R1: While reset is low, sync_found, rx_active and bit_strobe are 0 and miss_count is 0.
- R2: Acquisition starts only after D- is seen high. If D- stays low after reset for any length of time, no sync_found pulse and no miss are produced.
- R3: An attempt is abandoned when a K from idle is followed by J and D- then stays high for more than 16 clocks. miss_count then increases by exactly one. It never changes while rx_active is 1.
- R4: For a sync field of 11-clock bits K,J,K,J,K,J,K,K (K = D- low with D+ high, J = the reverse), sync_found is a single-clock pulse. It is seen 19 clocks after the final J-to-K transition appears at the pins.
- R5: When the line is J one and a half bits after a J-to-K edge, the search resumes on the next K edge. A line alternating K and J every 11 clocks never produces sync_found, and neither does it count a miss.
- R6: rx_active becomes 1 together with sync_found and stays 1 until eop_seen is sampled high, after which it is 0 on the next clock.
- R7: The first bit_strobe follows sync_found by exactly 11 clocks. At each strobe, bit_dm and bit_dp carry the synchronized D- and D+ levels of the bit being sampled.
- R8: At exactly 11 clocks per bit, successive strobes are 11 clocks apart and every sampled level equals the level driven for that bit.
- R9: With bit lengths 1% longer or shorter than nominal, and a transition at least every 7 bits, every sampled level still matches the driven level.
- R10: Consecutive strobes are never closer than 10 or further than 12 clocks apart, even when a one-clock glitch falls inside a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 11 cycles per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_dm | input | 1 | Raw D- pin level |
| line_dp | input | 1 | Raw D+ pin level |
| eop_seen | input | 1 | End-of-packet indication from the decoder |
| sync_found | output | 1 | One-clock pulse when the sync field is confirmed |
| rx_active | output | 1 | High from sync confirmation until end of packet |
| bit_strobe | output | 1 | One-clock pulse at each bit centre |
| bit_dm | output | 1 | D- level sampled at the strobe |
| bit_dp | output | 1 | D+ level sampled at the strobe |
| miss_count | output | 8 | Count of abandoned sync searches |

## Verification
The strobe-spacing checks assume the line holds each level for about a bit and changes at least once every seven bits, as bit stuffing guarantees. They also assume any glitch lasts one clock and lands away from the bit centre. The stimulus builds bit lengths from a hundredths-of-a-clock accumulator at nominal or one percent off, flips the level after six equal bits, and places glitches two clocks into a bit. The end-of-packet input is asserted only after an SE0 stretch, while the block is tracking.

// File: rtl/lsrx_pkg.sv
package lsrx_pkg;
  typedef enum logic [2:0] {
    AQ_WAIT_J,
    AQ_ARM,
    AQ_WAIT_J2,
    AQ_SEEK,
    AQ_CONFIRM,
    AQ_TRACK
  } aq_state_e;

  typedef enum logic [1:0] {
    ADJ_NONE,
    ADJ_SHORT,
    ADJ_LONG
  } adj_e;
endpackage

// File: rtl/lsrx_sync2.sv
module lsrx_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
    end
  end

  assign d_out = stage2_q;
endmodule

// File: rtl/lsrx_acq.sv
module lsrx_acq
  import lsrx_pkg::*;
#(
  parameter int CLK_PER_BIT = 11,
  parameter int SEEK_WIN    = 16,
  parameter int MISS_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dm_s,
  input  logic              eop_seen,
  output logic              tracking,
  output logic              lock_now,
  output logic              sync_pulse,
  output logic [MISS_W-1:0] miss_count
);
  localparam int HALF    = CLK_PER_BIT / 2;
  localparam int CONF_AT = CLK_PER_BIT + HALF;
  localparam int CMAX    = (SEEK_WIN > CONF_AT) ? SEEK_WIN : CONF_AT;
  localparam int AW      = $clog2(CMAX + 1);

  aq_state_e         st_q, st_n;
  logic [AW-1:0]     cnt_q, cnt_n;
  logic              miss_inc;
  logic              sync_q;
  logic [MISS_W-1:0] miss_q;

  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    lock_now = 1'b0;
    miss_inc = 1'b0;
    case (st_q)
      AQ_WAIT_J: begin
        if (dm_s) st_n = AQ_ARM;
      end
      AQ_ARM: begin
        if (!dm_s) st_n = AQ_WAIT_J2;
      end
      AQ_WAIT_J2: begin
        if (dm_s) begin
          st_n  = AQ_SEEK;
          cnt_n = AW'(1);
        end
      end
      AQ_SEEK: begin
        if (!dm_s) begin
          st_n  = AQ_CONFIRM;
          cnt_n = AW'(1);
        end else if (cnt_q >= AW'(SEEK_WIN)) begin
          st_n     = AQ_WAIT_J;
          cnt_n    = '0;
          miss_inc = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      AQ_CONFIRM: begin
        if (cnt_q == AW'(CONF_AT)) begin
          if (!dm_s) begin
            st_n     = AQ_TRACK;
            cnt_n    = '0;
            lock_now = 1'b1;
          end else begin
            st_n  = AQ_SEEK;
            cnt_n = AW'(1);
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      AQ_TRACK: begin
        if (eop_seen) st_n = AQ_WAIT_J;
      end
      default: begin
        st_n  = AQ_WAIT_J;
        cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= AQ_WAIT_J;
      cnt_q  <= '0;
      sync_q <= 1'b0;
      miss_q <= '0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sync_q <= lock_now;
      if (miss_inc) miss_q <= miss_q + 1'b1;
    end
  end

  assign tracking   = (st_q == AQ_TRACK);
  assign sync_pulse = sync_q;
  assign miss_count = miss_q;
endmodule

// File: rtl/lsrx_phase_trk.sv
module lsrx_phase_trk
  import lsrx_pkg::*;
#(
  parameter int CLK_PER_BIT = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic load,
  input  logic dm_s,
  input  logic dp_s,
  output logic strobe,
  output logic smp_dm,
  output logic smp_dp
);
  localparam int HALF     = CLK_PER_BIT / 2;
  localparam int EDGE_NOM = CLK_PER_BIT - 1 - HALF;
  localparam int PW       = $clog2(CLK_PER_BIT + 1);

  logic [PW-1:0] pcnt_q, pcnt_n;
  adj_e          adj_q, adj_n, adj_now;
  logic          dm_d_q;
  logic          strobe_q, strobe_n;
  logic          smp_dm_q, smp_dm_n, smp_dp_q, smp_dp_n;
  logic          edge_hit;
  logic [PW-1:0] last_cnt;
  logic          wrap;

  assign edge_hit = en && (dm_s != dm_d_q);

  always_comb begin
    adj_now = adj_q;
    if (edge_hit && (adj_q == ADJ_NONE)) begin
      if (pcnt_q < PW'(EDGE_NOM))      adj_now = ADJ_SHORT;
      else if (pcnt_q > PW'(EDGE_NOM)) adj_now = ADJ_LONG;
    end
    case (adj_now)
      ADJ_SHORT: last_cnt = PW'(CLK_PER_BIT - 2);
      ADJ_LONG:  last_cnt = PW'(CLK_PER_BIT);
      default:   last_cnt = PW'(CLK_PER_BIT - 1);
    endcase
    wrap = en && (pcnt_q >= last_cnt);
  end

  always_comb begin
    pcnt_n   = pcnt_q;
    adj_n    = adj_q;
    strobe_n = 1'b0;
    smp_dm_n = smp_dm_q;
    smp_dp_n = smp_dp_q;
    if (load) begin
      pcnt_n = '0;
      adj_n  = ADJ_NONE;
    end else if (en) begin
      if (wrap) begin
        pcnt_n   = '0;
        adj_n    = ADJ_NONE;
        strobe_n = 1'b1;
        smp_dm_n = dm_s;
        smp_dp_n = dp_s;
      end else begin
        pcnt_n = pcnt_q + 1'b1;
        adj_n  = adj_now;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q   <= '0;
      adj_q    <= ADJ_NONE;
      dm_d_q   <= 1'b0;
      strobe_q <= 1'b0;
      smp_dm_q <= 1'b0;
      smp_dp_q <= 1'b0;
    end else begin
      pcnt_q   <= pcnt_n;
      adj_q    <= adj_n;
      dm_d_q   <= dm_s;
      strobe_q <= strobe_n;
      smp_dm_q <= smp_dm_n;
      smp_dp_q <= smp_dp_n;
    end
  end

  assign strobe = strobe_q;
  assign smp_dm = smp_dm_q;
  assign smp_dp = smp_dp_q;
endmodule

// File: rtl/lsrx_sync_lock.sv
module lsrx_sync_lock #(
  parameter int CLK_PER_BIT = 11,
  parameter int SEEK_WIN    = 16,
  parameter int MISS_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_dm,
  input  logic              line_dp,
  input  logic              eop_seen,
  output logic              sync_found,
  output logic              rx_active,
  output logic              bit_strobe,
  output logic              bit_dm,
  output logic              bit_dp,
  output logic [MISS_W-1:0] miss_count
);
  logic [1:0] pins_s;
  logic       tracking;
  logic       lock_now;

  lsrx_sync2 #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({line_dp, line_dm}),
    .d_out (pins_s)
  );

  lsrx_acq #(
    .CLK_PER_BIT (CLK_PER_BIT),
    .SEEK_WIN    (SEEK_WIN),
    .MISS_W      (MISS_W)
  ) u_acq (
    .clk        (clk),
    .rst_n      (rst_n),
    .dm_s       (pins_s[0]),
    .eop_seen   (eop_seen),
    .tracking   (tracking),
    .lock_now   (lock_now),
    .sync_pulse (sync_found),
    .miss_count (miss_count)
  );

  lsrx_phase_trk #(.CLK_PER_BIT(CLK_PER_BIT)) u_trk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (tracking),
    .load   (lock_now),
    .dm_s   (pins_s[0]),
    .dp_s   (pins_s[1]),
    .strobe (bit_strobe),
    .smp_dm (bit_dm),
    .smp_dp (bit_dp)
  );

  assign rx_active = tracking;
endmodule

// File: rtl/lsrx_sync_lock_chk.sv
module lsrx_sync_lock_chk #(
  parameter int CLK_PER_BIT = 11,
  parameter int MISS_W      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eop_seen,
  input logic              sync_found,
  input logic              rx_active,
  input logic              bit_strobe,
  input logic [MISS_W-1:0] miss_count
);
  logic [4:0] gap_q;
  logic       first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      first_q <= 1'b0;
    end else begin
      if (sync_found || bit_strobe) gap_q <= 5'd1;
      else if (gap_q != 5'd31)      gap_q <= gap_q + 5'd1;
      if (sync_found)      first_q <= 1'b1;
      else if (bit_strobe) first_q <= 1'b0;
    end
  end

  assert_first_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && first_q) |-> (gap_q == 5'(CLK_PER_BIT)));

  assert_strobe_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && !first_q) |->
      ((gap_q >= 5'(CLK_PER_BIT - 1)) && (gap_q <= 5'(CLK_PER_BIT + 1))));

  assert_sync_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_found |=> !sync_found);

  assert_active_on_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_found |-> rx_active);

  assert_eop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && eop_seen) |=> !rx_active);

  assert_miss_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miss_count) |-> (miss_count == $past(miss_count) + 1'b1));

  assert_miss_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miss_count) |-> !rx_active);

  assert_strobe_in_packet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> $past(rx_active));
endmodule

bind lsrx_sync_lock lsrx_sync_lock_chk #(
  .CLK_PER_BIT (CLK_PER_BIT),
  .MISS_W      (MISS_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .eop_seen   (eop_seen),
  .sync_found (sync_found),
  .rx_active  (rx_active),
  .bit_strobe (bit_strobe),
  .miss_count (miss_count)
);

// File: tb/lsrx_sync_lock_test.sv
module lsrx_sync_lock_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_dm, line_dp, eop_seen;
  logic       sync_found, rx_active, bit_strobe, bit_dm, bit_dp;
  logic [7:0] miss_count;

  always #5 clk = ~clk;

  lsrx_sync_lock uut (
    .clk(clk), .rst_n(rst_n), .line_dm(line_dm), .line_dp(line_dp),
    .eop_seen(eop_seen), .sync_found(sync_found), .rx_active(rx_active),
    .bit_strobe(bit_strobe), .bit_dm(bit_dm), .bit_dp(bit_dp),
    .miss_count(miss_count)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int sync_cnt = 0;
  int sync_cyc = 0;
  int last_stb = -1;
  int mon_idx = 0;
  int n_exp = 0;
  int exp_miss = 0;
  bit exact_mode = 1'b1;
  bit exp_lv [0:127];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // Monitor: samples registered outputs at the falling edge.
  always @(negedge clk) begin
    if (rst_n && sync_found) begin
      sync_cnt++;
      sync_cyc = cyc;
      last_stb = -1;
    end
    if (rst_n && bit_strobe) begin
      if (last_stb < 0)
        chk(cyc - sync_cyc == 11, "R7 first strobe delay", cyc - sync_cyc, 11);
      else if (exact_mode)
        chk(cyc - last_stb == 11, "R8 strobe spacing", cyc - last_stb, 11);
      else
        chk((cyc - last_stb >= 10) && (cyc - last_stb <= 12), "R10 strobe spacing",
            cyc - last_stb, 11);
      if (mon_idx < n_exp) begin
        chk((bit_dm == exp_lv[mon_idx]) && (bit_dp == !bit_dm),
            exact_mode ? "R8 sampled level" : "R9 sampled level",
            {bit_dp, bit_dm}, {!exp_lv[mon_idx], exp_lv[mon_idx]});
        mon_idx++;
      end
      last_stb = cyc;
    end
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog actual=%0d expected<%0d", cyc, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Bench function: next line level with a forced flip after six equal bits.
  function automatic bit next_level(input bit prev, input int run);
    if (run >= 6) return !prev;
    return bit'($urandom_range(0, 1));
  endfunction

  task automatic drive(input bit lv, input int n);
    for (int i = 0; i < n; i++) begin
      line_dm = lv;
      line_dp = !lv;
      @(negedge clk);
    end
  endtask

  task automatic drive_se0(input int n);
    for (int i = 0; i < n; i++) begin
      line_dm = 1'b0;
      line_dp = 1'b0;
      @(negedge clk);
    end
  endtask

  // Sends idle, optional K/J toggles, sync, data and SE0, then end of packet.
  task automatic send_packet(input int nbits, input int per, input int glitch_at,
                             input int toggles);
    int  mark;
    int  acc;
    int  prev_edge;
    int  len;
    int  run;
    int  sync_before;
    int  miss_before;
    bit  lv;
    run = 0;
    lv = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      bit nl;
      nl = next_level(lv, run);
      run = (nl == lv) ? run + 1 : 1;
      lv = nl;
      exp_lv[i] = lv;
    end
    n_exp = nbits;
    mon_idx = 0;
    exact_mode = (per == 1100) && (glitch_at < 0);
    miss_before = exp_miss;
    drive(1'b1, 20);
    for (int t = 0; t < toggles; t++) begin
      drive(1'b0, 11);
      drive(1'b1, 11);
    end
    sync_before = sync_cnt;
    for (int s = 0; s < 6; s++) drive(s[0], 11);
    chk(sync_cnt == sync_before, "R5 no sync before final K", sync_cnt - sync_before, 0);
    mark = cyc;
    drive(1'b0, 22);
    acc = 0;
    prev_edge = 0;
    for (int i = 0; i < nbits; i++) begin
      acc = acc + per;
      len = acc / 100 - prev_edge;
      prev_edge = acc / 100;
      if (i == glitch_at) begin
        drive(exp_lv[i], 2);
        drive(!exp_lv[i], 1);
        drive(exp_lv[i], len - 3);
      end else begin
        drive(exp_lv[i], len);
      end
    end
    drive_se0(22);
    chk(sync_cnt == sync_before + 1, "R4 one sync pulse", sync_cnt - sync_before, 1);
    chk(sync_cyc - mark == 19, "R4 sync delay", sync_cyc - mark, 19);
    chk(mon_idx == nbits, exact_mode ? "R8 bits sampled" : "R9 bits sampled",
        mon_idx, nbits);
    chk(rx_active == 1'b1, "R6 active during packet", rx_active, 1);
    eop_seen = 1'b1;
    @(negedge clk);
    eop_seen = 1'b0;
    chk(rx_active == 1'b0, "R6 cleared after eop", rx_active, 0);
    chk(int'(miss_count) == miss_before, "R3 no miss on good packet",
        miss_count, miss_before);
    drive(1'b1, 20);
  endtask

  initial begin
    int seed_val;
    seed_val = $urandom(32'd4711);
    rst_n = 1'b0;
    line_dm = 1'b0;
    line_dp = 1'b0;
    eop_seen = 1'b0;
    repeat (4) @(negedge clk);
    chk({sync_found, rx_active, bit_strobe} == 3'b000, "R1 reset outputs",
        {sync_found, rx_active, bit_strobe}, 0);
    chk(miss_count == 8'd0, "R1 reset miss count", miss_count, 0);
    rst_n = 1'b1;

    // R2: D- held low for a long time, nothing may happen.
    drive_se0(150);
    drive(1'b0, 150);
    chk(sync_cnt == 0, "R2 no sync while D- low", sync_cnt, 0);
    chk(miss_count == 8'd0, "R2 no miss while D- low", miss_count, 0);
    chk(rx_active == 1'b0, "R2 idle while D- low", rx_active, 0);

    // R3: K from idle, then J that stays far past the search window.
    for (int m = 0; m < 3; m++) begin
      drive(1'b1, 20);
      drive(1'b0, 11);
      drive(1'b1, 40);
      exp_miss++;
      chk(int'(miss_count) == exp_miss, "R3 miss counted", miss_count, exp_miss);
    end
    chk(sync_cnt == 0, "R3 no sync on miss", sync_cnt, 0);

    // Directed packets at nominal rate, with a toggling prefix (R5).
    send_packet(24, 1100, -1, 0);
    send_packet(32, 1100, -1, 10);
    // Directed drift corners (R9) and glitch (R10).
    send_packet(64, 1111, -1, 0);
    send_packet(64, 1089, -1, 0);
    send_packet(40, 1100, 7, 0);

    // Constrained random packets.
    for (int p = 0; p < 20; p++) begin
      int sel;
      int per;
      int glt;
      sel = $urandom_range(0, 2);
      per = (sel == 0) ? 1100 : ((sel == 1) ? 1111 : 1089);
      glt = ($urandom_range(0, 3) == 0) ? $urandom_range(2, 15) : -1;
      send_packet($urandom_range(16, 64), per, glt, $urandom_range(0, 3));
    end

    // R5: endless K/J alternation never locks; the trailing J counts one miss.
    begin
      int sb;
      sb = sync_cnt;
      drive(1'b1, 20);
      for (int t = 0; t < 20; t++) begin
        drive(1'b0, 11);
        drive(1'b1, 11);
      end
      chk(sync_cnt == sb, "R5 no sync on alternation", sync_cnt - sb, 0);
      chk(int'(miss_count) == exp_miss, "R5 no miss during alternation",
          miss_count, exp_miss);
      drive(1'b1, 40);
      exp_miss++;
      chk(int'(miss_count) == exp_miss, "R3 miss after alternation", miss_count, exp_miss);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule